// File: doc/BRIEF.md
# Selectable-Timebase Event Counter

This block is a free-running 16-bit up-counter. An 8-bit mode register picks what makes it step. The choices are the system clock divided by 12 or by 4, every system clock, a one-cycle timer-overflow strobe, falling edges on an external pin, or an oscillator on its own clock that is divided by 8 in its own domain. The external pin and the divided oscillator are resynchronised into the system clock domain before they are used. Two select codes are reserved and make the counter hold.

The mode register also has an idle-suspend bit and an overflow interrupt enable. When the idle-suspend bit is set, the counter and its prescaler freeze while the CPU reports idle. When the counter wraps, a sticky overflow flag is set. The flag stays set until a clear strobe arrives. The flag, gated by the interrupt enable, drives the interrupt request.

Top module: `tbc_top`

## Requirements
- R1: After reset, count is 0x0000, ovf_flag is 0, irq is 0 and mode_rdata is 0x00.
- R2: A write stores bit 7 as idle-suspend, bits 3:1 as the source select and bit 0 as the interrupt enable. Bits 6:4 ignore the write and read as 0, so mode_rdata equals the written value AND 0x8F.
- R3: With select 100, count rises by one on every clock edge.
- R4: Select 000 steps the count once every 12 clocks and select 001 once every 4 clocks. A write that changes the select restarts the prescaler, so after N clocks following that write the count has risen by exactly floor(N/12) or floor(N/4).
- R5: With select 010, count rises by one on each clock edge at which tmr_ovf is high.
- R6: With select 011, each high-to-low change of ext_in adds one to the count. Each level must last at least 2 clocks. The count steps on the third clock edge after the falling edge, and not before.
- R7: With select 101, the count steps once for every 8 cycles of osc_clk.
- R8: Selects 110 and 111 leave the count unchanged.
- R9: When idle-suspend is 1 and cpu_idle is high, the count does not change. When idle-suspend is 0, cpu_idle has no effect on counting.
- R10: A step from 0xFFFF gives 0x0000 and sets ovf_flag on that same edge. The flag then stays set until flag_clr is pulsed. If a wrap and a clear happen in the same cycle, the set wins.
- R11: irq is high exactly when ovf_flag is 1 and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_idle | input | 1 | CPU idle indication |
| ext_in | input | 1 | External event pin, counted on falling edges |
| tmr_ovf | input | 1 | One-cycle timer overflow strobe |
| osc_clk | input | 1 | External oscillator, asynchronous to clk |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register read value |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
A prescaler left at a stale phase shows up in the first window after a select change. There the count falls short of floor(N/12) or floor(N/4) within one prescale period. A synchroniser stage too many or too few moves the external-edge step off the third clock edge, and a latency probe catches that at once. A wrong wrap or flag state shows on ovf_flag and irq in the cycle right after count passes 0xFFFF. The sticky and clear behaviour is visible in the next few cycles.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int MODE_W   = 8;
  localparam int IDLE_BIT = 7;
  localparam int SEL_HI   = 3;
  localparam int SEL_LO   = 1;
  localparam int IE_BIT   = 0;
  localparam logic [MODE_W-1:0] MODE_MASK = 8'h8F;
  localparam int MAX_DIV  = 12;
  localparam int PRE_W    = $clog2(MAX_DIV + 1);

  typedef enum logic [2:0] {
    SRC_DIV12 = 3'd0,
    SRC_DIV4  = 3'd1,
    SRC_TMR   = 3'd2,
    SRC_EXT   = 3'd3,
    SRC_SYS   = 3'd4,
    SRC_OSC   = 3'd5,
    SRC_RSV6  = 3'd6,
    SRC_RSV7  = 3'd7
  } src_e;

  function automatic logic [PRE_W-1:0] pre_limit(input src_e s);
    case (s)
      SRC_DIV12: return PRE_W'(MAX_DIV);
      SRC_DIV4:  return PRE_W'(4);
      default:   return PRE_W'(1);
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_clean(input logic [MODE_W-1:0] v);
    return v & MODE_MASK;
  endfunction
endpackage

// File: rtl/tbc_prescaler.sv
module tbc_prescaler import tbc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] phase;
  logic             last;

  assign last = (phase >= limit - PRE_W'(1));
  assign tick = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (advance) phase <= last ? '0 : phase + PRE_W'(1);
  end
endmodule

// File: rtl/tbc_sync_edge.sv
module tbc_sync_edge #(
  parameter bit RISING    = 1'b1,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic pulse
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {3{RESET_VAL}};
    else        sh <= {sh[1:0], d};
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = sh[1] & ~sh[2];
    end else begin : g_fall
      assign pulse = sh[2] & ~sh[1];
    end
  endgenerate
endmodule

// File: rtl/tbc_osc_div.sv
module tbc_osc_div #(
  parameter int DIV_W = 3
) (
  input  logic osc_clk,
  input  logic rst_n,
  output logic toggle
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + DIV_W'(1);
  end

  assign toggle = cnt[DIV_W-1];
endmodule

// File: rtl/tbc_top.sv
module tbc_top import tbc_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int OSC_DIV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_idle,
  input  logic              ext_in,
  input  logic              tmr_ovf,
  input  logic              osc_clk,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_rdata,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag,
  output logic              irq
);
  logic [MODE_W-1:0] mode_q;
  src_e              src;
  logic              run, restart;
  logic              pre_tick, ext_tick, osc_tog, osc_tick;
  logic              src_tick, cnt_inc, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= mode_clean(mode_wdata);
  end
  assign mode_rdata = mode_q;

  assign src     = src_e'(mode_q[SEL_HI:SEL_LO]);
  assign run     = ~(mode_q[IDLE_BIT] & cpu_idle);
  assign restart = mode_wr && (mode_wdata[SEL_HI:SEL_LO] != mode_q[SEL_HI:SEL_LO]);

  tbc_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(run),
    .limit(pre_limit(src)), .tick(pre_tick)
  );

  tbc_sync_edge #(.RISING(1'b0), .RESET_VAL(1'b1)) u_ext (
    .clk(clk), .rst_n(rst_n), .d(ext_in), .pulse(ext_tick)
  );

  tbc_osc_div #(.DIV_W(OSC_DIV_W)) u_odiv (
    .osc_clk(osc_clk), .rst_n(rst_n), .toggle(osc_tog)
  );

  tbc_sync_edge #(.RISING(1'b1), .RESET_VAL(1'b0)) u_osc (
    .clk(clk), .rst_n(rst_n), .d(osc_tog), .pulse(osc_tick)
  );

  always_comb begin
    case (src)
      SRC_DIV12, SRC_DIV4: src_tick = pre_tick;
      SRC_TMR:             src_tick = tmr_ovf;
      SRC_EXT:             src_tick = ext_tick;
      SRC_SYS:             src_tick = 1'b1;
      SRC_OSC:             src_tick = osc_tick;
      default:             src_tick = 1'b0;
    endcase
  end

  assign cnt_inc = run & src_tick;
  assign wrap    = cnt_inc && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (cnt_inc)       count <= count + CNT_W'(1);
      if (wrap)          ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
    end
  end

  assign irq = ovf_flag & mode_q[IE_BIT];
endmodule

// File: rtl/tbc_chk.sv
module tbc_chk import tbc_pkg::*; #(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_idle,
  input logic              flag_clr,
  input logic [MODE_W-1:0] mode_rdata,
  input logic [CNT_W-1:0]  count,
  input logic              ovf_flag,
  input logic              irq,
  input logic              cnt_inc
);
  logic [2:0] sel;
  assign sel = mode_rdata[SEL_HI:SEL_LO];

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rdata[6:4] == 3'b000);

  assert_reserved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2] && sel[1]) |=> $stable(count));

  assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rdata[IDLE_BIT] && cpu_idle) |=> $stable(count));

  assert_wrap_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && count == {CNT_W{1'b1}}) |=> (ovf_flag && count == '0));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(count) || count == $past(count) + CNT_W'(1)));

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag |-> !irq);
endmodule

bind tbc_top tbc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_idle(cpu_idle), .flag_clr(flag_clr),
  .mode_rdata(mode_rdata), .count(count), .ovf_flag(ovf_flag), .irq(irq),
  .cnt_inc(cnt_inc)
);

// File: tb/tbc_top_bench.sv
module tbc_top_bench;
  logic        clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic        cpu_idle = 1'b0, ext_in = 1'b1, tmr_ovf = 1'b0;
  logic        mode_wr = 1'b0, flag_clr = 1'b0;
  logic [7:0]  mode_wdata = '0, mode_rdata;
  logic [15:0] count;
  logic        ovf_flag, irq;

  int n_pass = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always #3 osc_clk = ~osc_clk;

  tbc_top u_tbc_top (
    .clk(clk), .rst_n(rst_n), .cpu_idle(cpu_idle), .ext_in(ext_in),
    .tmr_ovf(tmr_ovf), .osc_clk(osc_clk), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .mode_rdata(mode_rdata), .flag_clr(flag_clr),
    .count(count), .ovf_flag(ovf_flag), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] mode;
    logic       idle;
    logic [15:0] n;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h08, 1'b0, 16'd20, 16'd20},  // R3 every clock
    '{8'h00, 1'b0, 16'd36, 16'd3},   // R4 div 12
    '{8'h02, 1'b0, 16'd40, 16'd10},  // R4 div 4
    '{8'h00, 1'b0, 16'd6,  16'd0},   // R4 partial phase
    '{8'h02, 1'b0, 16'd8,  16'd2},   // R4 restart after switch
    '{8'h88, 1'b1, 16'd30, 16'd0},   // R9 suspended
    '{8'h08, 1'b1, 16'd15, 16'd15},  // R9 idle ignored
    '{8'h0C, 1'b0, 16'd30, 16'd0},   // R8 code 110
    '{8'h0E, 1'b0, 16'd30, 16'd0},   // R8 code 111
    '{8'hF8, 1'b0, 16'd10, 16'd10},  // R2 unused bits ignored
    '{8'h84, 1'b0, 16'd12, 16'd0},   // R5 no strobes
    '{8'h02, 1'b1, 16'd16, 16'd4}    // R9 idle with suspend off, div 4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    if (act === exp) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v, input logic idle);
    @(negedge clk);
    cpu_idle = idle; mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mode", mode_rdata, 8'h00);
    rst_n = 1'b1;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      wr_mode(VEC[i].mode, VEC[i].idle);
      chk("R2 readback", mode_rdata, VEC[i].mode & 8'h8F);
      c0 = count;
      repeat (int'(VEC[i].n)) @(negedge clk);
      chk($sformatf("R3/R4/R8/R9 vec%0d", i), count - c0, VEC[i].exp);
    end
    cpu_idle = 1'b0;

    // R5 timer strobes
    wr_mode(8'h04, 1'b0);
    c0 = count;
    for (int k = 0; k < 5; k++) begin
      tmr_ovf = 1'b1; @(negedge clk);
      tmr_ovf = 1'b0; repeat (3) @(negedge clk);
    end
    chk("R5 strobes", count - c0, 5);

    // R6 external falling edges: latency then count
    wr_mode(8'h06, 1'b0);
    c0 = count;
    ext_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 early", count - c0, 0);
    @(negedge clk);
    chk("R6 latency", count - c0, 1);
    ext_in = 1'b1; repeat (3) @(negedge clk);
    c0 = count;
    for (int k = 0; k < 4; k++) begin
      ext_in = 1'b0; repeat (2) @(negedge clk);
      ext_in = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R6 edges", count - c0, 4);

    // R7 oscillator divided by 8: 240 osc cycles -> about 30 steps
    wr_mode(8'h0A, 1'b0);
    c0 = count;
    #1440;
    @(negedge clk);
    c0 = count - c0;
    chk("R7 osc rate", (c0 >= 29 && c0 <= 31), 1);

    // R10/R11 wrap
    wr_mode(8'h09, 1'b0);
    while (count != 16'hFFFF) @(negedge clk);
    chk("R10 pre-wrap flag", ovf_flag, 0);
    @(negedge clk);
    chk("R10 wrap count", count, 16'h0000);
    chk("R10 wrap flag", ovf_flag, 1);
    chk("R11 irq enabled", irq, 1);
    wr_mode(8'h08, 1'b0);
    chk("R11 irq masked", irq, 0);
    repeat (5) @(negedge clk);
    chk("R10 sticky", ovf_flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R10 cleared", ovf_flag, 0);
    chk("R11 irq low", irq, 0);

    finished = 1'b1;
    finish_run();
  end
endmodule